// File: doc/BRIEF.md
# Page Write Buffer and Program-Cycle Sequencer

This block collects the data bytes of one page write arriving from a serial-bus front end, then hands them to a storage array during a self-timed programming window. The bus controller first presents a starting address. It then presents data bytes one at a time, and finally raises a commit strobe when the bus transaction ends. The buffer holds one page of 32 bytes. A per-entry enable mask records which entries were actually loaded. A five-bit column pointer advances with each byte and wraps inside the page, and the page number never changes during a load.

On commit, a hardware write-protect rule is applied. If anything is left to write, a busy window of a parameterised number of clocks opens; that count stands for the multi-millisecond programming time. During the first cycles of that window the loaded entries are written into the array through a simple write port, one per clock, in ascending column order. Unloaded entries of the page are never written, so their old contents survive. While busy, every control input is ignored. The array itself, read access and bus protocol lie outside the block.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy and the array write strobe are low, and no byte is pending, so a commit with no loads does nothing.
- R2: An address load while idle sets the page number (address bits 13..5) and column (bits 4..0) and discards every byte loaded before it.
- R3: Each byte load stores the byte at the current column and advances the column by one, wrapping from 31 to 0; the page number does not change.
- R4: When the column wraps onto an entry that was already loaded, the later byte replaces the earlier one.
- R5: A commit with at least one writable byte raises busy on the next clock, and busy then stays high for exactly PROG_CYCLES clocks.
- R6: While busy, each loaded entry produces one array write with address {page, column}, one per clock, in ascending column order starting in the first busy cycle; entries never loaded produce no write.
- R7: With the protect input high, a commit whose page lies in the top quarter (address bits 13:12 = 11) does nothing: no busy and no writes. With protect low, or a lower page, the commit proceeds.
- R8: A commit with no byte loaded leaves busy low and makes no write.
- R9: Address loads, byte loads and commits that arrive while busy are ignored.
- R10: The pending bytes are cleared when the busy window ends, so a second commit without new loads does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Hardware write-protect level |
| ld_addr_vld | input | 1 | Start a new page load at ld_addr |
| ld_addr | input | 14 | Byte address: page in bits 13..5, column in bits 4..0 |
| ld_byte_vld | input | 1 | Store ld_byte at the current column |
| ld_byte | input | 8 | Data byte to buffer |
| commit | input | 1 | End of data phase; start programming |
| busy | output | 1 | Programming window in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 14 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The protection assertion assumes that the protect input is held steady for the whole busy window, because the rule is applied once, at commit. The bench changes it only while the block is idle. The checks also assume that no two of address load, byte load and commit arrive in the same cycle. The bench issues each as a one-clock pulse in its own cycle. The pulses sent during busy are the single deliberate exception, and there the block ignores all of them.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_PROG = 1'b1
   } seq_state_e;

   // Bits needed to count from zero up to n inclusive.
   function automatic int unsigned count_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned OFFS_W     = 5,
   parameter int unsigned PAGE_W     = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_en,
   input  logic [PAGE_W-1:0]     addr_page,
   input  logic [OFFS_W-1:0]     addr_col,
   input  logic                  byte_en,
   input  logic [DATA_W-1:0]     byte_in,
   input  logic                  clr,
   input  logic [OFFS_W-1:0]     rd_col,
   output logic [PAGE_W-1:0]     page,
   output logic [PAGE_BYTES-1:0] mask,
   output logic [DATA_W-1:0]     rd_data
);

   logic [OFFS_W-1:0] col_q;
   logic [PAGE_W-1:0] page_q;
   logic [DATA_W-1:0] store [PAGE_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         page_q <= '0;
      end else if (addr_en) begin
         col_q  <= addr_col;
         page_q <= addr_page;
      end else if (clr) begin
         col_q  <= '0;
      end else if (byte_en) begin
         col_q  <= col_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
         logic              hit;
         logic              vld_q;
         logic [DATA_W-1:0] dat_q;

         assign hit = byte_en && (col_q == OFFS_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
            end else if (addr_en || clr) begin
               vld_q <= 1'b0;
            end else if (hit) begin
               vld_q <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (hit && !addr_en && !clr) begin
               dat_q <= byte_in;
            end
         end

         assign mask[g]  = vld_q;
         assign store[g] = dat_q;
      end
   endgenerate

   assign page    = page_q;
   assign rd_data = store[rd_col];

endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
   parameter int unsigned PAGE_W    = 9,
   parameter int unsigned PROT_BITS = 2
) (
   input  logic              wp,
   input  logic [PAGE_W-1:0] page,
   output logic              blocked
);

   generate
      if (PROT_BITS == 0) begin : g_none
         assign blocked = 1'b0;
      end else begin : g_region
         localparam logic [PAGE_W-1:0] THRESH =
            PAGE_W'(((1 << PROT_BITS) - 1) << (PAGE_W - PROT_BITS));
         assign blocked = wp && (page >= THRESH);
      end
   endgenerate

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
   import pwb_pkg::*;
#(
   parameter int unsigned PROG_CYCLES = 500000,
   parameter int unsigned PAGE_BYTES  = 32,
   parameter int unsigned OFFS_W      = 5,
   parameter int unsigned CNT_W       = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              scan_valid,
   output logic [OFFS_W-1:0] scan_col
);

   localparam logic [CNT_W-1:0] LAST     = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               cnt_q <= '0;
               if (start) begin
                  state_q <= SEQ_PROG;
               end
            end
            default: begin
               if (cnt_q == LAST) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy       = (state_q == SEQ_PROG);
   assign done       = busy && (cnt_q == LAST);
   assign scan_valid = busy && (cnt_q < SCAN_END);
   assign scan_col   = cnt_q[OFFS_W-1:0];

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
   import pwb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAGE_BYTES  = 32,
   parameter int unsigned PROG_CYCLES = 500000,
   parameter int unsigned PROT_BITS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp,
   input  logic              ld_addr_vld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_byte_vld,
   input  logic [DATA_W-1:0] ld_byte,
   input  logic              commit,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);

   localparam int unsigned OFFS_W = $clog2(PAGE_BYTES);
   localparam int unsigned PAGE_W = ADDR_W - OFFS_W;
   localparam int unsigned CNT_W  = count_width(PROG_CYCLES);

   generate
      if (PAGE_BYTES != (1 << OFFS_W)) begin : g_chk_pow2
         $error("PAGE_BYTES must be a power of two");
      end
      if (PROG_CYCLES < PAGE_BYTES) begin : g_chk_len
         $error("PROG_CYCLES must cover one write per page entry");
      end
      if (PROT_BITS > PAGE_W) begin : g_chk_prot
         $error("PROT_BITS exceeds the page number width");
      end
      if (OFFS_W >= ADDR_W) begin : g_chk_addr
         $error("ADDR_W must exceed the column width");
      end
   endgenerate

   logic                  seq_busy;
   logic                  seq_done;
   logic                  scan_valid;
   logic [OFFS_W-1:0]     scan_col;
   logic [PAGE_W-1:0]     page;
   logic [PAGE_BYTES-1:0] mask;
   logic [DATA_W-1:0]     rd_data;
   logic                  blocked;
   logic                  addr_en;
   logic                  byte_en;
   logic                  commit_ok;
   logic                  go;
   logic                  clr;

   // Inputs are accepted only while idle; an address load wins over a byte.
   assign addr_en   = ld_addr_vld && !seq_busy;
   assign byte_en   = ld_byte_vld && !seq_busy && !ld_addr_vld;
   assign commit_ok = commit && !seq_busy;
   assign go        = commit_ok && (|mask) && !blocked;
   assign clr       = seq_done || (commit_ok && !go);

   pwb_buffer #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES),
      .OFFS_W     (OFFS_W),
      .PAGE_W     (PAGE_W)
   ) u_buffer (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_en   (addr_en),
      .addr_page (ld_addr[ADDR_W-1:OFFS_W]),
      .addr_col  (ld_addr[OFFS_W-1:0]),
      .byte_en   (byte_en),
      .byte_in   (ld_byte),
      .clr       (clr),
      .rd_col    (scan_col),
      .page      (page),
      .mask      (mask),
      .rd_data   (rd_data)
   );

   pwb_protect #(
      .PAGE_W    (PAGE_W),
      .PROT_BITS (PROT_BITS)
   ) u_protect (
      .wp      (wp),
      .page    (page),
      .blocked (blocked)
   );

   pwb_sequencer #(
      .PROG_CYCLES (PROG_CYCLES),
      .PAGE_BYTES  (PAGE_BYTES),
      .OFFS_W      (OFFS_W),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (go),
      .busy       (seq_busy),
      .done       (seq_done),
      .scan_valid (scan_valid),
      .scan_col   (scan_col)
   );

   assign busy      = seq_busy;
   assign arr_we    = scan_valid && mask[scan_col];
   assign arr_addr  = {page, scan_col};
   assign arr_wdata = rd_data;

endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned PROG_CYCLES = 500000,
   parameter int unsigned PROT_BITS   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp,
   input logic              commit,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr
);

   localparam int unsigned CW = $clog2(PROG_CYCLES + 2);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!busy) begin
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit)); // R5

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < CW'(PROG_CYCLES))); // R5

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == CW'(PROG_CYCLES))); // R5

   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy); // R6

   AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |-> (arr_addr == $past(arr_addr) + 1'b1)); // R6

   generate
      if (PROT_BITS > 0) begin : g_prot
         AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (arr_we && wp) |-> !(&arr_addr[ADDR_W-1 -: PROT_BITS])); // R7
      end
   endgenerate

endmodule

bind page_prog_seq pwb_chk #(
   .ADDR_W      (ADDR_W),
   .PROG_CYCLES (PROG_CYCLES),
   .PROT_BITS   (PROT_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wp       (wp),
   .commit   (commit),
   .busy     (busy),
   .arr_we   (arr_we),
   .arr_addr (arr_addr)
);

// File: tb/page_prog_seq_tb.sv
`timescale 1ns/1ps
module page_prog_seq_tb;

   localparam int P = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp = 1'b0;
   logic        ld_addr_vld = 1'b0;
   logic [13:0] ld_addr = '0;
   logic        ld_byte_vld = 1'b0;
   logic [7:0]  ld_byte = '0;
   logic        commit = 1'b0;
   logic        busy;
   logic        arr_we;
   logic [13:0] arr_addr;
   logic [7:0]  arr_wdata;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   page_prog_seq #(.PROG_CYCLES(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .wp(wp),
      .ld_addr_vld(ld_addr_vld), .ld_addr(ld_addr),
      .ld_byte_vld(ld_byte_vld), .ld_byte(ld_byte),
      .commit(commit), .busy(busy),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
   );

   // Log of array writes
   int          log_n = 0;
   logic [13:0] log_a [64];
   logic [7:0]  log_d [64];

   always @(posedge clk) begin
      if (rst_n && arr_we && log_n < 64) begin
         log_a[log_n] = arr_addr;
         log_d[log_n] = arr_wdata;
         log_n = log_n + 1;
      end
   end

   // Requirement model of the page buffer
   logic [8:0] m_page = '0;
   logic [4:0] m_col  = '0;
   logic       m_vld [32];
   logic [7:0] m_dat [32];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_addr(input logic [13:0] a);
      @(negedge clk);
      ld_addr_vld = 1'b1;
      ld_addr     = a;
      @(negedge clk);
      ld_addr_vld = 1'b0;
      m_page = a[13:5];
      m_col  = a[4:0];
      for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
   endtask

   task automatic drive_byte(input logic [7:0] d);
      @(negedge clk);
      ld_byte_vld = 1'b1;
      ld_byte     = d;
      @(negedge clk);
      ld_byte_vld = 1'b0;
      m_vld[m_col] = 1'b1;
      m_dat[m_col] = d;
      m_col = m_col + 1'b1;
   endtask

   task automatic run_commit(output int len);
      log_n = 0;
      @(negedge clk);
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      len = 0;
      while (busy) begin
         len++;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_model();
      for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
   endtask

   task automatic expect_writes(input string req);
      int k;
      int cnt;
      cnt = 0;
      for (int i = 0; i < 32; i++) if (m_vld[i]) cnt++;
      chk(log_n == cnt, req, "write count", log_n, cnt);
      k = 0;
      for (int i = 0; i < 32; i++) begin
         if (m_vld[i] && k < log_n) begin
            chk(log_a[k] == {m_page, 5'(i)}, req, "write address", log_a[k], {m_page, 5'(i)});
            chk(log_d[k] == m_dat[i], req, "write data", log_d[k], m_dat[i]);
            k++;
         end
      end
      clear_model();
   endtask

   // R1: reset state
   task automatic t_reset();
      int len;
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(arr_we == 1'b0, "R1", "write strobe after reset", arr_we, 0);
      run_commit(len);
      chk(len == 0, "R1", "busy cycles on commit after reset", len, 0);
      chk(log_n == 0, "R1", "writes on commit after reset", log_n, 0);
   endtask

   // R3, R5, R6: full page and busy length
   task automatic t_full_page();
      int len;
      drive_addr(14'h0120);
      for (int i = 0; i < 32; i++) drive_byte(8'(i) ^ 8'h5A);
      run_commit(len);
      chk(len == P, "R5", "busy length", len, P);
      expect_writes("R6");
   endtask

   // R3, R6: partial load wrapping inside the page
   task automatic t_wrap_partial();
      int len;
      drive_addr({9'h1A5, 5'd30});
      drive_byte(8'hA0);
      drive_byte(8'hA1);
      drive_byte(8'hA2);
      drive_byte(8'hA3);
      run_commit(len);
      chk(len == P, "R5", "busy length partial", len, P);
      expect_writes("R3");
   endtask

   // R4: wrap onto a loaded entry overwrites it
   task automatic t_overwrite();
      int len;
      drive_addr({9'h033, 5'd5});
      for (int i = 0; i < 33; i++) drive_byte(8'(i + 1));
      chk(m_dat[5] == 8'd33, "R4", "model overwrite value", m_dat[5], 33);
      run_commit(len);
      expect_writes("R4");
   endtask

   // R7: protection
   task automatic t_protect();
      int len;
      wp = 1'b1;
      drive_addr(14'h3044);
      drive_byte(8'h11);
      drive_byte(8'h22);
      drive_byte(8'h33);
      run_commit(len);
      chk(len == 0, "R7", "busy on protected commit", len, 0);
      chk(log_n == 0, "R7", "writes on protected commit", log_n, 0);
      clear_model();
      drive_addr(14'h2FE0);
      drive_byte(8'h44);
      drive_byte(8'h55);
      run_commit(len);
      chk(len == P, "R7", "busy on lower page with protect", len, P);
      expect_writes("R7");
      wp = 1'b0;
      drive_addr(14'h3FE0);
      drive_byte(8'h66);
      drive_byte(8'h77);
      run_commit(len);
      chk(len == P, "R7", "busy on top page without protect", len, P);
      expect_writes("R7");
   endtask

   // R8: commit with nothing loaded
   task automatic t_empty();
      int len;
      drive_addr(14'h0200);
      run_commit(len);
      chk(len == 0, "R8", "busy on empty commit", len, 0);
      chk(log_n == 0, "R8", "writes on empty commit", log_n, 0);
   endtask

   // R9, R10: inputs ignored while busy; buffer cleared after the window
   task automatic t_busy_ignore();
      int len;
      drive_addr(14'h0400);
      drive_byte(8'h11);
      drive_byte(8'h22);
      log_n = 0;
      @(negedge clk);
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      chk(busy == 1'b1, "R5", "busy one clock after commit", busy, 1);
      repeat (3) @(negedge clk);
      ld_addr_vld = 1'b1;
      ld_addr     = 14'h0800;
      @(negedge clk);
      ld_addr_vld = 1'b0;
      ld_byte_vld = 1'b1;
      ld_byte     = 8'h99;
      @(negedge clk);
      ld_byte_vld = 1'b0;
      commit      = 1'b1;
      @(negedge clk);
      commit      = 1'b0;
      len = 0;
      while (busy) begin
         len++;
         @(negedge clk);
      end
      chk(len == P - 6, "R9", "remaining busy cycles", len, P - 6);
      repeat (3) @(negedge clk);
      expect_writes("R9");
      run_commit(len);
      chk(len == 0, "R10", "busy on second commit", len, 0);
      chk(log_n == 0, "R10", "writes on second commit", log_n, 0);
   endtask

   // R2: a new address load discards earlier bytes
   task automatic t_reload();
      int len;
      drive_addr(14'h0A00);
      drive_byte(8'hC1);
      drive_byte(8'hC2);
      drive_addr(14'h0B07);
      drive_byte(8'hD1);
      run_commit(len);
      expect_writes("R2");
   endtask

   initial begin
      #(10 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      clear_model();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_page();
      t_wrap_partial();
      t_overwrite();
      t_protect();
      t_empty();
      t_busy_ignore();
      t_reload();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule